// File: doc/BRIEF.md
# USXGMII Transmit Symbol Replicator

This block sits between a 32-bit, four-lane transmit symbol source and a PCS that runs at the fixed 10G line rate. Each lane carries one byte plus a flag that marks the byte as a control character. Slower Ethernet rates ride on the fixed line rate by sending every source word once and then repeating it a number of times. The number of repeats depends on a configured speed code and on whether the link runs in the 10G-based or the 5G-based mode. While copies are being sent, the block drops its ready output so that the source holds its next word.

Copies of frame delimiters are rewritten so that the receiver never sees a frame boundary twice. In copies of a start word, lane 0 becomes a plain data byte. Copies of a terminate word become idle. A single-cycle start-of-packet pulse marks only the first copy of a start word. Replication can be switched off at run time, and the block then passes words through at full rate.

Top module: `usx_tx_replicator`

## Requirements
- R1: With the 5G-based mode off (`cfgHalfRate`=0), speed code `cfgSpeed` selects the number of repeats N per word: 3'b000→999, 3'b001→99, 3'b010→9, 3'b011→0, 3'b100→3, 3'b101→1, and any other code→0.
- R2: With `cfgHalfRate`=1, the mapping is: 3'b000→499, 3'b001→49, 3'b010→4, 3'b100→1, 3'b101→0, and any other code→0.
- R3: With replication on, a word is accepted only on a rising edge where `srcReady` is high. The first copy appears on the outputs in the cycle after that edge. `srcReady` is then low for exactly N cycles and is high again in the cycle that shows the last copy, so one word is accepted every N+1 cycles.
- R4: Data words, idle words and any other word without a start or terminate character appear N+1 times in a row, unchanged. Lane i occupies data bits [8i+7:8i] and control bit i.
- R5: A start word is one with control bit 0 set and byte 0 equal to 8'hFB. In every repeat of a start word, byte 0 is 8'hAA and control bit 0 is clear. Lanes 1 to 3 are unchanged.
- R6: A terminate word has 8'hFD with its control bit set in any one of the four lanes. It is shown once, and all N of its repeats are the idle word.
- R7: `outSop` is high for exactly the one cycle that shows the first copy of a start word. It is low during the repeats of that word and at all other times.
- R8: With `cfgRepEnable` low, no repeats occur. `srcReady` stays high, and each word is accepted on every edge and shown once.
- R9: While `rst` is high (synchronous), the outputs show the idle word, with data 32'h07070707 and control 4'hF. `outSop` and `srcReady` are low. On the first edge after `rst` falls, the repeat counter reloads and `srcReady` rises.
- R10: A change of `cfgSpeed` or `cfgHalfRate` does not alter the repetition already in progress. It takes effect at the next counter reload, that is, for the next word accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous reset, active high |
| cfgRepEnable | input | 1 | Turns word replication on |
| cfgHalfRate | input | 1 | Selects the 5G-based repeat table |
| cfgSpeed | input | 3 | Link speed code |
| srcData | input | 32 | Source word, four bytes, lane 0 in bits 7:0 |
| srcCtrl | input | 4 | Control flag per source lane |
| srcReady | output | 1 | Source word is taken on this edge |
| outData | output | 32 | Word toward the PCS |
| outCtrl | output | 4 | Control flags toward the PCS |
| outSop | output | 1 | Marks the first copy of a start word |

## Verification
A wrong repeat counter or stall flag shows at the ports within a single word period. The gap between `srcReady` pulses grows or shrinks, and a source word is dropped or shown too few times, already for the first word after a reload. A faulty copy rewrite shows one cycle after a delimiter is accepted: a second start byte, a surviving terminate, or a repeated `outSop`. A speed change that is applied too early shortens or stretches the very word that is being repeated when the change arrives.

// File: rtl/usx_rep_pkg.sv
package usx_rep_pkg;

  localparam int LANE_W = 8;

  localparam logic [LANE_W-1:0] CH_IDLE  = 8'h07;
  localparam logic [LANE_W-1:0] CH_START = 8'hFB;
  localparam logic [LANE_W-1:0] CH_TERM  = 8'hFD;
  localparam logic [LANE_W-1:0] CH_FILL  = 8'hAA;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;    // take a new source word
    logic holdCopy;  // emit a repeat of the held word
  } repStrobe_t;

  function automatic int repCount(input logic halfRate, input logic [2:0] code);
    int n;
    n = 0;
    if (halfRate) begin
      case (code)
        3'b000:  n = 499;
        3'b001:  n = 49;
        3'b010:  n = 4;
        3'b100:  n = 1;
        default: n = 0;
      endcase
    end else begin
      case (code)
        3'b000:  n = 999;
        3'b001:  n = 99;
        3'b010:  n = 9;
        3'b100:  n = 3;
        3'b101:  n = 1;
        default: n = 0;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/usx_rep_ctrl.sv
module usx_rep_ctrl
  import usx_rep_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfgEnable,
  input  logic       cfgHalfRate,
  input  logic [2:0] cfgSpeed,
  output repStrobe_t strobe,
  output logic       srcReady
);

  logic [CNT_W-1:0] repCnt;
  logic             stallFlag;
  logic             runReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      repCnt    <= '0;
      stallFlag <= 1'b0;
      runReady  <= 1'b0;
    end else begin
      runReady <= 1'b1;
      if (cfgEnable) begin
        if (repCnt == '0) begin
          repCnt    <= CNT_W'(repCount(cfgHalfRate, cfgSpeed));
          stallFlag <= 1'b0;
        end else begin
          repCnt    <= repCnt - 1'b1;
          stallFlag <= 1'b1;
        end
      end else begin
        repCnt    <= '0;
        stallFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.accept   = runReady && !stallFlag;
    strobe.holdCopy = stallFlag;
  end

  assign srcReady = strobe.accept;

endmodule

// File: rtl/usx_rep_dpath.sv
module usx_rep_dpath
  import usx_rep_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  repStrobe_t              strobe,
  input  logic [LANES*LANE_W-1:0] srcData,
  input  logic [LANES-1:0]        srcCtrl,
  output logic [LANES*LANE_W-1:0] outData,
  output logic [LANES-1:0]        outCtrl,
  output logic                    outSop
);

  localparam int DATA_W = LANES * LANE_W;
  localparam logic [DATA_W-1:0] IDLE_WORD = {LANES{CH_IDLE}};

  logic [LANES-1:0]  termLane;
  logic              heldStart;
  logic              srcStart;
  logic [DATA_W-1:0] nextData;
  logic [LANES-1:0]  nextCtrl;
  logic              nextSop;

  for (genvar i = 0; i < LANES; i++) begin : g_term
    assign termLane[i] = outCtrl[i] && (outData[i*LANE_W +: LANE_W] == CH_TERM);
  end

  assign heldStart = outCtrl[0] && (outData[LANE_W-1:0] == CH_START);
  assign srcStart  = srcCtrl[0] && (srcData[LANE_W-1:0] == CH_START);

  always_comb begin
    nextData = outData;
    nextCtrl = outCtrl;
    nextSop  = 1'b0;
    if (strobe.accept) begin
      nextData = srcData;
      nextCtrl = srcCtrl;
      nextSop  = srcStart;
    end else if (strobe.holdCopy) begin
      if (|termLane) begin
        nextData = IDLE_WORD;
        nextCtrl = '1;
      end else if (heldStart) begin
        nextData[LANE_W-1:0] = CH_FILL;
        nextCtrl[0]          = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outData <= IDLE_WORD;
      outCtrl <= '1;
      outSop  <= 1'b0;
    end else begin
      outData <= nextData;
      outCtrl <= nextCtrl;
      outSop  <= nextSop;
    end
  end

endmodule

// File: rtl/usx_tx_replicator.sv
module usx_tx_replicator
  import usx_rep_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CNT_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfgRepEnable,
  input  logic                    cfgHalfRate,
  input  logic [2:0]              cfgSpeed,
  input  logic [LANES*LANE_W-1:0] srcData,
  input  logic [LANES-1:0]        srcCtrl,
  output logic                    srcReady,
  output logic [LANES*LANE_W-1:0] outData,
  output logic [LANES-1:0]        outCtrl,
  output logic                    outSop
);

  repStrobe_t strobe;

  usx_rep_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cfgEnable   (cfgRepEnable),
    .cfgHalfRate (cfgHalfRate),
    .cfgSpeed    (cfgSpeed),
    .strobe      (strobe),
    .srcReady    (srcReady)
  );

  usx_rep_dpath #(.LANES(LANES)) i_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .srcData (srcData),
    .srcCtrl (srcCtrl),
    .outData (outData),
    .outCtrl (outCtrl),
    .outSop  (outSop)
  );

endmodule

// File: rtl/usx_rep_chk.sv
module usx_rep_chk
  import usx_rep_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cfgRepEnable,
  input logic                    srcReady,
  input logic [LANES*LANE_W-1:0] outData,
  input logic [LANES-1:0]        outCtrl,
  input logic                    outSop
);

  localparam int DATA_W = LANES * LANE_W;
  localparam logic [DATA_W-1:0] IDLE_WORD = {LANES{CH_IDLE}};

  logic isTerm;
  logic isStart;

  always_comb begin
    isTerm = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (outCtrl[i] && outData[i*LANE_W +: LANE_W] == CH_TERM) isTerm = 1'b1;
    end
    isStart = outCtrl[0] && (outData[LANE_W-1:0] == CH_START);
  end

  assert_hold_copy_R4: assert property (@(posedge clk) disable iff (rst)
    (!srcReady && !isTerm && !isStart) |=> ($stable(outData) && $stable(outCtrl)));

  assert_start_fill_R5: assert property (@(posedge clk) disable iff (rst)
    (isStart && !srcReady) |=>
      (outData[LANE_W-1:0] == CH_FILL && !outCtrl[0] && $stable(outData[DATA_W-1:LANE_W])));

  assert_term_once_R6: assert property (@(posedge clk) disable iff (rst)
    (isTerm && !srcReady) |=> (outData == IDLE_WORD && outCtrl == '1));

  assert_sop_single_R7: assert property (@(posedge clk) disable iff (rst)
    outSop |=> !outSop);

  assert_sop_on_start_R7: assert property (@(posedge clk) disable iff (rst)
    outSop |-> isStart);

  assert_full_rate_R8: assert property (@(posedge clk) disable iff (rst)
    (!cfgRepEnable && !$past(cfgRepEnable) && !$past(rst)) |-> srcReady);

  assert_reset_idle_R9: assert property (@(posedge clk)
    rst |=> (outData == IDLE_WORD && outCtrl == '1 && !srcReady && !outSop));

endmodule

bind usx_tx_replicator usx_rep_chk #(.LANES(LANES)) i_usx_rep_chk (
  .clk          (clk),
  .rst          (rst),
  .cfgRepEnable (cfgRepEnable),
  .srcReady     (srcReady),
  .outData      (outData),
  .outCtrl      (outCtrl),
  .outSop       (outSop)
);

// File: tb/test_usx_tx_replicator.sv
module test_usx_tx_replicator;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgRepEnable = 1'b1;
  logic        cfgHalfRate = 1'b0;
  logic [2:0]  cfgSpeed = 3'b011;
  logic [31:0] srcData = 32'h07070707;
  logic [3:0]  srcCtrl = 4'hF;
  logic        srcReady;
  logic [31:0] outData;
  logic [3:0]  outCtrl;
  logic        outSop;

  int checks = 0;
  int errors = 0;
  string extraTag = "";

  always #2 clk = ~clk;   // 250 MHz

  usx_tx_replicator i_usx_tx_replicator (
    .clk(clk), .rst(rst), .cfgRepEnable(cfgRepEnable), .cfgHalfRate(cfgHalfRate),
    .cfgSpeed(cfgSpeed), .srcData(srcData), .srcCtrl(srcCtrl), .srcReady(srcReady),
    .outData(outData), .outCtrl(outCtrl), .outSop(outSop)
  );

  typedef struct {
    logic [31:0] d;
    logic [3:0]  c;
    logic        sop;
    logic        rdy;
    string       tag;
    string       rtag;
  } item_t;

  item_t sb[$];

  // configuration as seen on the most recent edge (the reload edge)
  logic       snapEn = 1'b1;
  logic       snapHalf = 1'b0;
  logic [2:0] snapSpd = 3'b011;
  always @(posedge clk) begin
    snapEn   <= cfgRepEnable;
    snapHalf <= cfgHalfRate;
    snapSpd  <= cfgSpeed;
  end

  function automatic int expReps(input logic en, input logic half, input logic [2:0] s);
    if (!en) return 0;                        // R8
    if (half) begin                           // R2
      if (s == 3'b000) return 499;
      if (s == 3'b001) return 49;
      if (s == 3'b010) return 4;
      if (s == 3'b100) return 1;
      return 0;
    end
    if (s == 3'b000) return 999;              // R1
    if (s == 3'b001) return 99;
    if (s == 3'b010) return 9;
    if (s == 3'b100) return 3;
    if (s == 3'b101) return 1;
    return 0;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendWord(input logic [31:0] d, input logic [3:0] c, input bit chk);
    item_t it;
    int n;
    logic isStart, isTerm;
    forever begin
      @(negedge clk);
      srcData = d;
      srcCtrl = c;
      if (srcReady) begin
        if (chk) begin
          n = expReps(snapEn, snapHalf, snapSpd);
          isStart = c[0] && d[7:0] == 8'hFB;
          isTerm = 1'b0;
          for (int i = 0; i < 4; i++) if (c[i] && d[8*i +: 8] == 8'hFD) isTerm = 1'b1;
          it.rtag = !snapEn ? "R8" : (snapHalf ? "R2/R3" : "R1/R3");
          if (extraTag != "") it.rtag = {it.rtag, "/", extraTag};
          it.d = d; it.c = c; it.sop = isStart; it.rdy = (n == 0);
          it.tag = isStart ? "R7" : "R4";
          sb.push_back(it);
          for (int k = 1; k <= n; k++) begin
            it.sop = 1'b0;
            it.rdy = (k == n);
            if (isTerm) begin
              it.d = 32'h07070707; it.c = 4'hF; it.tag = "R6";
            end else if (isStart) begin
              it.d = {d[31:8], 8'hAA}; it.c = {c[3:1], 1'b0}; it.tag = "R5";
            end else begin
              it.d = d; it.c = c; it.tag = "R4";
            end
            sb.push_back(it);
          end
        end
        break;
      end
    end
  endtask

  // monitor: one expected item per cycle once a word is in flight
  always begin
    item_t e;
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      check({e.tag, " word"}, {28'd0, outCtrl, outData}, {28'd0, e.c, e.d});
      check("R7 sop", {63'd0, outSop}, {63'd0, e.sop});
      check({e.rtag, " ready"}, {63'd0, srcReady}, {63'd0, e.rdy});
    end
  end

  task automatic setCfg(input logic en, input logic half, input logic [2:0] s);
    @(negedge clk);
    cfgRepEnable = en;
    cfgHalfRate = half;
    cfgSpeed = s;
    sendWord(32'h07070707, 4'hF, 1'b0);
    sendWord(32'h07070707, 4'hF, 1'b0);
  endtask

  function automatic logic [35:0] termWord(input int lane);
    logic [31:0] d;
    logic [3:0]  c;
    for (int i = 0; i < 4; i++) begin
      if (i < lane) begin
        d[8*i +: 8] = 8'h40 + 8'(i); c[i] = 1'b0;
      end else if (i == lane) begin
        d[8*i +: 8] = 8'hFD; c[i] = 1'b1;
      end else begin
        d[8*i +: 8] = 8'h07; c[i] = 1'b1;
      end
    end
    return {c, d};
  endfunction

  task automatic runFrame(input int lane);
    logic [35:0] t;
    t = termWord(lane);
    sendWord(32'h555555FB, 4'b0001, 1'b1);
    sendWord(32'h03020100 + 32'(lane), 4'b0000, 1'b1);
    sendWord(32'hD5C3B2A1, 4'b0000, 1'b1);
    sendWord(t[31:0], t[35:32], 1'b1);
    sendWord(32'h07070707, 4'hF, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset data", {32'd0, outData}, {32'd0, 32'h07070707});
    check("R9 reset ctrl", {60'd0, outCtrl}, {60'd0, 4'hF});
    check("R9 reset sop", {63'd0, outSop}, 64'd0);
    check("R9 reset ready", {63'd0, srcReady}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 ready after reset", {63'd0, srcReady}, 64'd1);

    // 10G-based table, every code
    for (int s = 0; s < 8; s++) begin
      setCfg(1'b1, 1'b0, 3'(s));
      runFrame(s % 4);
    end
    // 5G-based table, every code
    for (int s = 0; s < 8; s++) begin
      setCfg(1'b1, 1'b1, 3'(s));
      runFrame((s + 1) % 4);
    end
    // replication off: full rate even with a slow speed code
    setCfg(1'b0, 1'b0, 3'b000);
    runFrame(1);
    runFrame(3);

    // R10: speed change during a long repetition applies from the next word
    setCfg(1'b1, 1'b0, 3'b000);
    extraTag = "R10";
    sendWord(32'h11223344, 4'b0000, 1'b1);
    cfgSpeed = 3'b011;
    sendWord(32'h55667788, 4'b0000, 1'b1);
    sendWord(32'h555555FB, 4'b0001, 1'b1);
    sendWord(32'h07FD0099, 4'b1100, 1'b1);
    extraTag = "";

    while (sb.size() > 0) @(posedge clk);
    repeat (4) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule